// File: doc/BRIEF.md
# Stream Frame Length Adjuster

This block sits inline on a byte-wide valid/ready stream. It forces every frame that passes through to a length between a lower and an upper bound, both given on plain input pins. A frame shorter than the lower bound is extended with zero bytes. A frame longer than the upper bound is cut off: the byte at the bound is sent with the end-of-frame marker, and the rest of the input frame is accepted and thrown away. The bounds are read on the first beat of each frame and held for the rest of that frame, so software may change them at any time without corrupting a frame that is already in flight.

When a frame ends, the block presents a one-beat status record on a separate valid/ready port. The record gives the length as received, the length as sent, and one flag each for truncation and padding. Back-pressure behaves as follows:
- Data beats pass through combinationally, so output ready reaches input ready directly while frame bytes are forwarded.
- During padding the input is held off.
- While the status record waits to be taken, the next frame is held off.

Top module: `frame_len_fixer`

## Requirements
- R1: A frame whose input length is below the effective minimum is sent with its own bytes, followed by 0x00 bytes until the output length equals the effective minimum. Only the last pad byte carries out_last.
- R2: A frame longer than the effective maximum is sent as its first max bytes, with out_last on byte number max. Every remaining input beat is accepted with in_ready high and produces no output.
- R3: The bounds are sampled on the first accepted beat of a frame. Changes to min_len or max_len later in the same frame have no effect on that frame.
- R4: st_orig_len reports the number of beats accepted on the input for the frame, including discarded beats.
- R5: st_sent_len reports the number of beats sent on the output for the frame, and it equals the number of output handshakes.
- R6: st_trunc is 1 exactly when the input length exceeded the effective maximum. st_pad is 1 exactly when the input length was below the effective minimum. The two flags are never both 1.
- R7: A beat moves only when valid and ready are both high. Frame bytes leave in input order with their values unchanged.
- R8: While pad bytes are being sent, in_ready is 0. The final input beat of a short frame is forwarded with out_last low.
- R9: From the end of a frame until st_valid && st_ready, in_ready is 0 and the status fields stay stable.
- R10: The effective maximum is max_len, or 1 when max_len is 0. The effective minimum is the smaller of min_len and the effective maximum, so the maximum wins when the bounds conflict.
- R11: The length counters are 16 bits wide and saturate at 65535. A longer frame reports st_orig_len = 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| min_len | input | 16 | Lower length bound in bytes |
| max_len | input | 16 | Upper length bound in bytes |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input beat valid |
| in_last | input | 1 | Input beat ends the frame |
| in_ready | output | 1 | Block accepts an input beat |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output beat valid |
| out_last | output | 1 | Output beat ends the frame |
| out_ready | input | 1 | Sink accepts an output beat |
| st_valid | output | 1 | Status record valid |
| st_ready | input | 1 | Status record accepted |
| st_orig_len | output | 16 | Length as received |
| st_sent_len | output | 16 | Length as sent |
| st_trunc | output | 1 | Frame was cut |
| st_pad | output | 1 | Frame was padded |

## Verification
The bench sweeps every combination of small bounds, including a zero maximum and a maximum below the minimum, against frame lengths that fall below, at and above each bound. It runs this sweep under several stall patterns on input, output and status. Each of the following errors shows up as a wrong byte, a misplaced out_last or a wrong status field:
- an off-by-one at a bound, which would cut or pad a frame one byte too soon;
- forwarding the original end-of-frame marker before the pads;
- letting a new frame in while padding or while status is pending;
- taking the bounds live instead of latching them.

A frame of 70000 bytes checks that the received length saturates instead of wrapping to a small value.

// File: rtl/flf_pkg.sv
package flf_pkg;
  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_PAD  = 2'd1,
    ST_DROP = 2'd2,
    ST_STAT = 2'd3
  } flf_state_e;
endpackage

// File: rtl/flf_sat_counter.sv
module flf_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && $past(cnt) == TOP && $past(rst_n) && !$past(clr)) |-> cnt == TOP); // R11
endmodule

// File: rtl/flf_limits.sv
module flf_limits #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] min_in,
  input  logic [W-1:0] max_in,
  input  logic         live,
  input  logic         load,
  output logic [W-1:0] eff_min,
  output logic [W-1:0] eff_max
);
  logic [W-1:0] cmax, cmin, min_q, max_q;

  always_comb begin
    cmax = (max_in == '0) ? W'(1) : max_in;
    cmin = (min_in < cmax) ? min_in : cmax;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      min_q <= '0;
      max_q <= W'(1);
    end else if (load) begin
      min_q <= cmin;
      max_q <= cmax;
    end
  end

  assign eff_min = live ? cmin : min_q;
  assign eff_max = live ? cmax : max_q;

  AST_MIN_LE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    eff_min <= eff_max && eff_max != '0); // R10
  AST_HELD_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!live && !load && $past(!load) && $past(!live)) |-> $stable(eff_max)); // R3
endmodule

// File: rtl/frame_len_fixer.sv
module frame_len_fixer
  import flf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  min_len,
  input  logic [LEN_W-1:0]  max_len,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_last,
  input  logic              out_ready,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [LEN_W-1:0]  st_orig_len,
  output logic [LEN_W-1:0]  st_sent_len,
  output logic              st_trunc,
  output logic              st_pad
);
  localparam int NW = LEN_W + 1;

  flf_state_e state, nxt;
  logic [LEN_W-1:0] in_cnt, out_cnt, eff_min, eff_max;
  logic [NW-1:0] n_next, min_w, max_w;
  logic inc_in, inc_out, clr_cnt, first, load, short_f, cut_f;
  logic trunc_q, pad_q;

  assign first   = (state == ST_DATA) && (out_cnt == '0);
  assign load    = first && in_valid && out_ready;
  assign clr_cnt = (state == ST_STAT) && st_ready;

  flf_limits #(.W(LEN_W)) u_lim (
    .clk(clk), .rst_n(rst_n), .min_in(min_len), .max_in(max_len),
    .live(first), .load(load), .eff_min(eff_min), .eff_max(eff_max)
  );

  flf_sat_counter #(.W(LEN_W)) u_in_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_cnt), .inc(inc_in), .cnt(in_cnt)
  );

  flf_sat_counter #(.W(LEN_W)) u_out_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_cnt), .inc(inc_out), .cnt(out_cnt)
  );

  assign n_next = {1'b0, out_cnt} + NW'(1);
  assign min_w  = {1'b0, eff_min};
  assign max_w  = {1'b0, eff_max};
  assign short_f = in_last && (n_next < min_w);
  assign cut_f   = !in_last && (n_next >= max_w);

  always_comb begin
    nxt       = state;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    st_valid  = 1'b0;
    inc_in    = 1'b0;
    inc_out   = 1'b0;
    case (state)
      ST_DATA: begin
        out_valid = in_valid;
        out_data  = in_data;
        in_ready  = out_ready;
        out_last  = (in_last && !short_f) || cut_f;
        if (in_valid && out_ready) begin
          inc_in  = 1'b1;
          inc_out = 1'b1;
          if (short_f)      nxt = ST_PAD;
          else if (in_last) nxt = ST_STAT;
          else if (cut_f)   nxt = ST_DROP;
        end
      end
      ST_PAD: begin
        out_valid = 1'b1;
        out_last  = n_next >= min_w;
        if (out_ready) begin
          inc_out = 1'b1;
          if (out_last) nxt = ST_STAT;
        end
      end
      ST_DROP: begin
        in_ready = 1'b1;
        if (in_valid) begin
          inc_in = 1'b1;
          if (in_last) nxt = ST_STAT;
        end
      end
      default: begin
        st_valid = 1'b1;
        if (st_ready) nxt = ST_DATA;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_DATA;
      trunc_q <= 1'b0;
      pad_q   <= 1'b0;
    end else begin
      state <= nxt;
      if (clr_cnt) begin
        trunc_q <= 1'b0;
        pad_q   <= 1'b0;
      end else if (state == ST_DATA && nxt == ST_DROP) begin
        trunc_q <= 1'b1;
      end else if (state == ST_DATA && nxt == ST_PAD) begin
        pad_q <= 1'b1;
      end
    end
  end

  assign st_orig_len = in_cnt;
  assign st_sent_len = out_cnt;
  assign st_trunc    = trunc_q;
  assign st_pad      = pad_q;

  AST_SENT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> st_sent_len >= eff_min); // R1
  AST_SENT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> st_sent_len <= eff_max); // R2
  AST_TRUNC_LONGER: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_trunc) |-> st_orig_len >= st_sent_len); // R4
  AST_PAD_SHORTER: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_pad) |-> st_orig_len < st_sent_len); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> !(st_trunc && st_pad)); // R6
  AST_PAD_HOLDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data == '0 && state == ST_PAD) |-> !in_ready); // R8
  AST_STAT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> !in_ready && !out_valid); // R9
  AST_STAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> st_valid && $stable(st_orig_len) && $stable(st_sent_len)
      && $stable(st_trunc) && $stable(st_pad)); // R9
endmodule

// File: tb/frame_len_fixer_test.sv
module frame_len_fixer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] min_len = '0, max_len = '0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0, st_ready = 1'b0;
  logic in_ready, out_valid, out_last, st_valid, st_trunc, st_pad;
  logic [7:0] out_data;
  logic [15:0] st_orig_len, st_sent_len;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_len_fixer uut (
    .clk(clk), .rst_n(rst_n), .min_len(min_len), .max_len(max_len),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
    .st_valid(st_valid), .st_ready(st_ready), .st_orig_len(st_orig_len),
    .st_sent_len(st_sent_len), .st_trunc(st_trunc), .st_pad(st_pad)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] byte_of(input int len, input int i);
    return 8'((len * 16 + i * 7 + 1) | 1);
  endfunction

  // pat: 0 no stalls, 1 output stalls, 2 input gaps, 3 status stalls
  task automatic run_frame(input int mn, input int mx, input int len, input int pat);
    int emax, emin, sent, si, ri, tmo;
    bit done;
    emax = (mx == 0) ? 1 : mx;                    // R10
    emin = (mn < emax) ? mn : emax;
    sent = (len > emax) ? emax : ((len < emin) ? emin : len);
    si = 0; ri = 0; done = 0; tmo = 0;
    while (!done) begin
      @(negedge clk);
      cyc++; tmo++;
      // R3: bounds change to misleading values once the frame has started
      min_len  = (si == 0) ? 16'(mn) : 16'(mn + 3);
      max_len  = (si == 0) ? 16'(mx) : 16'(mx ^ 2);
      in_valid = (si < len) && !(pat == 2 && (cyc % 3 == 0));
      in_data  = byte_of(len, si);
      in_last  = (si == len - 1);
      out_ready = !(pat == 1 && (cyc % 2 == 0));
      st_ready  = !(pat == 3 && (tmo % 4 != 0));
      #1;
      if (ri >= len && ri < sent && out_valid)
        check(!in_ready, "R8 in_ready during pad", in_ready, 0);
      if (st_valid) begin
        check(!in_ready, "R9 in_ready while status pending", in_ready, 0);
        check(!out_valid, "R9 out_valid while status pending", out_valid, 0);
      end
      if (out_valid && out_ready) begin
        if (ri < len)
          check(out_data == byte_of(len, ri), "R7 data byte", out_data, byte_of(len, ri));
        else
          check(out_data == 8'h00, "R1 pad byte", out_data, 0);
        check(out_last == (ri == sent - 1), (len > emax) ? "R2 out_last" : "R1 out_last",
              out_last, (ri == sent - 1));
        ri++;
      end
      if (in_valid && in_ready) si++;
      if (st_valid && st_ready) begin
        check(st_orig_len == 16'(len > 65535 ? 65535 : len), "R4 orig length", st_orig_len, len);
        check(st_sent_len == 16'(sent), "R5 sent length", st_sent_len, sent);
        check(ri == sent, "R5 output beat count", ri, sent);
        check(si == len, "R2 input beats consumed", si, len);
        check(st_trunc == (len > emax), "R6 truncated flag", st_trunc, len > emax);
        check(st_pad == (len < emin), "R6 padded flag", st_pad, len < emin);
        done = 1;
      end
      if (tmo > 400 + len * 3) begin
        check(0, "R7 frame timeout", ri, sent);
        done = 1;
      end
    end
    in_valid = 0;
  endtask

  task automatic run_long(input int len, input int mx);
    int si, ri, tmo;
    bit done;
    si = 0; ri = 0; done = 0; tmo = 0;
    while (!done) begin
      @(negedge clk);
      cyc++; tmo++;
      min_len = 16'd0; max_len = 16'(mx);
      in_valid = (si < len); in_data = 8'(si); in_last = (si == len - 1);
      out_ready = 1; st_ready = 1;
      #1;
      if (out_valid && out_ready) ri++;
      if (in_valid && in_ready) si++;
      if (st_valid && st_ready) begin
        check(st_orig_len == 16'hFFFF, "R11 saturated orig length", st_orig_len, 65535);
        check(st_sent_len == 16'(mx), "R11 sent length", st_sent_len, mx);
        check(st_trunc == 1'b1, "R11 truncated flag", st_trunc, 1);
        done = 1;
      end
      if (tmo > len + 100) begin
        check(0, "R11 long frame timeout", si, len);
        done = 1;
      end
    end
    in_valid = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid, "R7 reset out_valid", out_valid, 0);
    check(!st_valid, "R9 reset st_valid", st_valid, 0);
    for (int pat = 0; pat < 4; pat++)
      for (int mn = 0; mn <= 4; mn++)
        for (int mx = 0; mx <= 5; mx++)
          for (int len = 1; len <= 7; len++)
            run_frame(mn, mx, len, pat);
    run_frame(6, 2, 1, 1);      // R10 maximum wins over a larger minimum
    run_frame(0, 0, 3, 0);      // R10 zero maximum behaves as one
    run_long(70000, 3);         // R11
    run_frame(3, 5, 1, 0);      // R1 after saturation frame, counters cleared
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule